// File: doc/BRIEF.md
# Paired-Block Interrupt Status and Vector Front End

This block is the interrupt and address front end of an eight-channel serial controller. The eight channels are grouped into four blocks of two. The channel datapaths sit outside this block. They report transmit-ready, receive-ready and break conditions as per-channel set and clear pulses. The front end keeps an 8-bit status register and an 8-bit mask register for each block. It merges pairs of blocks onto two registered interrupt lines.

A host reaches the block through single-cycle bus accesses in one of three spaces:
- **I/O space** decodes a byte address into block, channel and register offset. The combined status/mask location is the only one implemented.
- **ID space** serves a fixed 12-byte identification table and takes the interrupt vector write.
- **Acknowledge space** returns the stored vector on a valid acknowledge address.

Read data is registered. It appears the cycle after the read and holds until the next read.

Top module: `sio_irq_front`

## Requirements
- R1: In I/O space the block index is bus_addr[7:5] and the register offset is bus_addr[4:0] XOR 1. An access whose block index is 4 or more, or whose offset is not 0x0B, reads 0 and changes nothing.
- R2: Each channel c drives three event bits: index 3c+0 is transmit-ready, 3c+1 is receive-ready and 3c+2 is break. Channel c maps to block c/2. An even channel uses status bits 0, 1 and 2. An odd channel uses status bits 4, 5 and 6. Status bits 3 and 7 stay 0.
- R3: A set pulse makes its status bit 1 at the next clock edge. A clear pulse makes it 0. When both arrive in the same cycle, set wins.
- R4: An I/O read at offset 0x0B (byte address 32·b+0x0A) returns the status of block b. An I/O write there loads the mask of block b. The mask itself is never returned on reads.
- R5: irq[0] is 1 when (status AND mask) is nonzero for block 0 or block 1. irq[1] does the same for blocks 2 and 3. Each line is registered and reflects the status and mask as they stood one cycle earlier.
- R6: A write in ID space (bus_space=1) to address 1 stores the interrupt vector. ID-space writes to any other address change nothing.
- R7: A read in acknowledge space (bus_space=2) at address 0 or 2 returns the stored vector. Any other acknowledge address returns 0.
- R8: An ID-space read at address a returns entry a/2 of the table 53 49 4F 38 01 08 10 00 00 00 0C A5 (hex, entry 0 first). It returns 0 when a/2 is 12 or more.
- R9: After reset all status, mask and vector registers are 0, both interrupt lines are 0 and read data is 0.
- R10: bus_rdata updates only at the edge that accepts a read (bus_valid=1, bus_write=0) and holds otherwise. A read with bus_space=3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_space | input | 2 | 0 I/O, 1 ID, 2 acknowledge, 3 unused |
| bus_addr | input | 8 | Byte address within the space |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_set | input | 24 | Per-channel status set pulses, index 3c+k |
| evt_clr | input | 24 | Per-channel status clear pulses, index 3c+k |
| irq | output | 2 | Interrupt lines, one per pair of blocks |

## Verification
Directed cases drive single events on even and odd channels of different blocks. Reading back the status bytes separates the lane and block mapping from a plain bit-index mapping. They also drive a set and clear of the same bit in one cycle, which exposes the set-wins ordering. Mask writes to decoys (offset 0x0A, block index 4) and a staged mask-then-event sequence show that:
- the interrupt lines follow exactly one cycle behind,
- each line covers only its own pair of blocks.

Vector and table reads at valid, neighbouring and out-of-range addresses separate the address qualifiers. A long random phase mixes sparse overlapping set/clear pulses with random mask writes and reads in all spaces. Every cycle it is compared against a bench model.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    typedef enum logic [1:0] {
        SP_IO   = 2'd0,
        SP_ID   = 2'd1,
        SP_ACK  = 2'd2,
        SP_NONE = 2'd3
    } bus_space_e;

    localparam int EV_KINDS    = 3;
    localparam int LANE_STRIDE = 4;
    localparam int STAT_W      = 8;
    localparam int ID_LEN      = 12;
    localparam logic [4:0] OFS_STAT_MASK = 5'h0B;
    localparam logic [7:0] VEC_WR_ADDR   = 8'd1;

    typedef struct packed {
        logic [2:0] blk;
        logic [4:0] ofs;
    } io_dec_t;

    function automatic io_dec_t decode_io(input logic [7:0] a);
        io_dec_t d;
        d.blk = a[7:5];
        d.ofs = a[4:0] ^ 5'h01;
        return d;
    endfunction

    function automatic int stat_pos(input int lane, input int kind);
        return lane * LANE_STRIDE + kind;
    endfunction

    function automatic logic [7:0] id_byte(input logic [6:0] idx);
        logic [7:0] v;
        case (idx)
            7'd0:    v = 8'h53;
            7'd1:    v = 8'h49;
            7'd2:    v = 8'h4F;
            7'd3:    v = 8'h38;
            7'd4:    v = 8'h01;
            7'd5:    v = 8'h08;
            7'd6:    v = 8'h10;
            7'd10:   v = 8'h0C;
            7'd11:   v = 8'hA5;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sio_irq_decode.sv
module sio_irq_decode
    import sio_irq_pkg::*;
#(
    parameter int N_BLK = 4,
    localparam int BLK_W = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
    input  logic             bus_valid_i,
    input  logic             bus_write_i,
    input  logic [1:0]       bus_space_i,
    input  logic [7:0]       bus_addr_i,
    output logic [N_BLK-1:0] mask_we_o,
    output logic [BLK_W-1:0] stat_sel_o,
    output logic             stat_hit_o,
    output logic             vec_we_o,
    output logic             ack_hit_o,
    output logic             rd_en_o
);
    io_dec_t dec;
    logic    is_io;
    logic    blk_ok;

    always_comb begin
        dec        = decode_io(bus_addr_i);
        is_io      = (bus_space_i == SP_IO);
        blk_ok     = (int'(dec.blk) < N_BLK);
        stat_hit_o = is_io && blk_ok && (dec.ofs == OFS_STAT_MASK);
        stat_sel_o = dec.blk[BLK_W-1:0];
        rd_en_o    = bus_valid_i && !bus_write_i;
        vec_we_o   = bus_valid_i && bus_write_i && (bus_space_i == SP_ID)
                     && (bus_addr_i == VEC_WR_ADDR);
        ack_hit_o  = (bus_space_i == SP_ACK)
                     && ((bus_addr_i == 8'd0) || (bus_addr_i == 8'd2));
        for (int b = 0; b < N_BLK; b++) begin
            mask_we_o[b] = bus_valid_i && bus_write_i && stat_hit_o
                           && (int'(dec.blk) == b);
        end
    end
endmodule

// File: rtl/sio_irq_blkstat.sv
module sio_irq_blkstat
    import sio_irq_pkg::*;
#(
    parameter int LANES = 2,
    localparam int EV_W = LANES * EV_KINDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EV_W-1:0]   set_i,
    input  logic [EV_W-1:0]   clr_i,
    input  logic              mask_we_i,
    input  logic [STAT_W-1:0] mask_wd_i,
    output logic [STAT_W-1:0] stat_o,
    output logic [STAT_W-1:0] mask_o,
    output logic              pend_o
);
    logic [STAT_W-1:0] stat_q, stat_d;
    logic [STAT_W-1:0] mask_q;

    always_comb begin
        stat_d = stat_q;
        for (int l = 0; l < LANES; l++) begin
            for (int k = 0; k < EV_KINDS; k++) begin
                if (set_i[l*EV_KINDS + k]) begin
                    stat_d[stat_pos(l, k)] = 1'b1;
                end else if (clr_i[l*EV_KINDS + k]) begin
                    stat_d[stat_pos(l, k)] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= stat_d;
            if (mask_we_i) begin
                mask_q <= mask_wd_i;
            end
        end
    end

    assign stat_o = stat_q;
    assign mask_o = mask_q;
    assign pend_o = |(stat_q & mask_q);
endmodule

// File: rtl/sio_irq_merge.sv
module sio_irq_merge #(
    parameter int N_BLK = 4,
    localparam int N_IRQ = N_BLK / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_BLK-1:0] pend_i,
    output logic [N_IRQ-1:0] irq_o
);
    for (genvar j = 0; j < N_IRQ; j++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                irq_o[j] <= 1'b0;
            end else begin
                irq_o[j] <= pend_i[2*j] | pend_i[2*j+1];
            end
        end
    end
endmodule

// File: rtl/sio_irq_front.sv
module sio_irq_front
    import sio_irq_pkg::*;
#(
    parameter int N_CH = 8,
    localparam int N_BLK = N_CH / 2,
    localparam int N_IRQ = N_BLK / 2,
    localparam int EV_W  = N_CH * EV_KINDS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [1:0]       bus_space,
    input  logic [7:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [EV_W-1:0]  evt_set,
    input  logic [EV_W-1:0]  evt_clr,
    output logic [N_IRQ-1:0] irq
);
    localparam int BLK_W   = (N_BLK > 1) ? $clog2(N_BLK) : 1;
    localparam int BLK_EVW = 2 * EV_KINDS;

    logic [N_BLK-1:0]        mask_we;
    logic [BLK_W-1:0]        stat_sel;
    logic                    stat_hit, vec_we, ack_hit, rd_en;
    logic [N_BLK*STAT_W-1:0] stat_flat, mask_flat;
    logic [N_BLK-1:0]        pend;
    logic [7:0]              vec_q, rd_next, rdata_q;

    sio_irq_decode #(.N_BLK(N_BLK)) u_dec (
        .bus_valid_i (bus_valid),
        .bus_write_i (bus_write),
        .bus_space_i (bus_space),
        .bus_addr_i  (bus_addr),
        .mask_we_o   (mask_we),
        .stat_sel_o  (stat_sel),
        .stat_hit_o  (stat_hit),
        .vec_we_o    (vec_we),
        .ack_hit_o   (ack_hit),
        .rd_en_o     (rd_en)
    );

    for (genvar b = 0; b < N_BLK; b++) begin : g_blk
        sio_irq_blkstat #(.LANES(2)) u_blk (
            .clk       (clk),
            .rst       (rst),
            .set_i     (evt_set[b*BLK_EVW +: BLK_EVW]),
            .clr_i     (evt_clr[b*BLK_EVW +: BLK_EVW]),
            .mask_we_i (mask_we[b]),
            .mask_wd_i (bus_wdata),
            .stat_o    (stat_flat[b*STAT_W +: STAT_W]),
            .mask_o    (mask_flat[b*STAT_W +: STAT_W]),
            .pend_o    (pend[b])
        );
    end

    sio_irq_merge #(.N_BLK(N_BLK)) u_merge (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend),
        .irq_o  (irq)
    );

    always_comb begin
        case (bus_space)
            SP_IO:   rd_next = stat_hit ? stat_flat[{stat_sel, 3'b000} +: STAT_W] : 8'h00;
            SP_ID:   rd_next = id_byte(bus_addr[7:1]);
            SP_ACK:  rd_next = ack_hit ? vec_q : 8'h00;
            default: rd_next = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (vec_we) begin
                vec_q <= bus_wdata;
            end
            if (rd_en) begin
                rdata_q <= rd_next;
            end
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/sio_irq_front_chk.sv
module sio_irq_front_chk
    import sio_irq_pkg::*;
#(
    parameter int N_CH = 8,
    localparam int N_BLK = N_CH / 2,
    localparam int N_IRQ = N_BLK / 2,
    localparam int EV_W  = N_CH * 3
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [1:0]         bus_space,
    input logic [7:0]         bus_addr,
    input logic [7:0]         bus_wdata,
    input logic [7:0]         bus_rdata,
    input logic [EV_W-1:0]    evt_set,
    input logic [EV_W-1:0]    evt_clr,
    input logic [N_IRQ-1:0]   irq,
    input logic [N_BLK*8-1:0] stat_flat,
    input logic [N_BLK*8-1:0] mask_flat,
    input logic [7:0]         vec_q
);
    logic arm;
    always_ff @(posedge clk) begin
        if (rst) arm <= 1'b0;
        else     arm <= 1'b1;
    end

    for (genvar j = 0; j < N_IRQ; j++) begin : g_irq
        AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
            arm |-> irq[j] == $past((|(stat_flat[(2*j)*8 +: 8] & mask_flat[(2*j)*8 +: 8]))
                                 || (|(stat_flat[(2*j+1)*8 +: 8] & mask_flat[(2*j+1)*8 +: 8])))); // R5
    end

    for (genvar i = 0; i < EV_W; i++) begin : g_ev
        localparam int C = i / 3;
        localparam int P = (C / 2) * 8 + (C % 2) * 4 + (i % 3);
        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            evt_set[i] |=> stat_flat[P]); // R3
        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
            (evt_clr[i] && !evt_set[i]) |=> !stat_flat[P]); // R3
    end

    for (genvar b = 0; b < N_BLK; b++) begin : g_mask
        AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
            (bus_valid && bus_write && bus_space == SP_IO
             && bus_addr[7:5] == 3'(b) && bus_addr[4:0] == 5'h0A)
            |=> mask_flat[b*8 +: 8] == $past(bus_wdata)); // R4
    end

    AST_VEC_STABLE: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && bus_write && bus_space == SP_ID && bus_addr == 8'd1)
        |=> $stable(vec_q)); // R6

    AST_ACK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_space == SP_ACK
         && bus_addr != 8'd0 && bus_addr != 8'd2) |=> bus_rdata == 8'h00); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata)); // R10
endmodule

bind sio_irq_front sio_irq_front_chk #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_space (bus_space),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_set   (evt_set),
    .evt_clr   (evt_clr),
    .irq       (irq),
    .stat_flat (stat_flat),
    .mask_flat (mask_flat),
    .vec_q     (vec_q)
);

// File: tb/test_sio_irq_front.sv
module test_sio_irq_front;
    localparam int N_CH = 8;
    localparam int EV_W = N_CH * 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst;
    logic            valid, write;
    logic [1:0]      space;
    logic [7:0]      addr, wdata;
    logic [7:0]      rdata;
    logic [EV_W-1:0] eset, eclr;
    logic [1:0]      irq;

    sio_irq_front #(.N_CH(N_CH)) i_sio_irq_front (
        .clk(clk), .rst(rst), .bus_valid(valid), .bus_write(write),
        .bus_space(space), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .evt_set(eset), .evt_clr(eclr), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_st [4];
    logic [7:0] m_mk [4];
    logic [7:0] m_vec, m_rd;

    function automatic logic [7:0] idtab(int i);
        logic [7:0] t [12] = '{8'h53, 8'h49, 8'h4F, 8'h38, 8'h01, 8'h08,
                               8'h10, 8'h00, 8'h00, 8'h00, 8'h0C, 8'hA5};
        return (i < 12) ? t[i] : 8'h00;
    endfunction

    function automatic logic [7:0] exp_read(logic [1:0] sp, logic [7:0] a);
        case (sp)
            2'd0: return (a[7:5] < 3'd4 && a[4:0] == 5'h0A) ? m_st[a[7:5]] : 8'h00;
            2'd1: return idtab(int'(a) / 2);
            2'd2: return (a == 8'd0 || a == 8'd2) ? m_vec : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        valid = 1'b0; write = 1'b0; space = 2'd3; addr = 8'h00; wdata = 8'h00;
        eset = '0; eclr = '0;
    endtask

    task automatic tick();
        logic [1:0] e_irq;
        logic       do_rd;
        logic [7:0] e_rd;
        @(posedge clk);
        #1;
        for (int j = 0; j < 2; j++)
            e_irq[j] = (|(m_st[2*j] & m_mk[2*j])) | (|(m_st[2*j+1] & m_mk[2*j+1]));
        do_rd = valid && !write;
        e_rd  = exp_read(space, addr);
        for (int c = 0; c < N_CH; c++) begin
            for (int k = 0; k < 3; k++) begin
                if (eset[c*3+k])      m_st[c/2][(c%2)*4+k] = 1'b1;
                else if (eclr[c*3+k]) m_st[c/2][(c%2)*4+k] = 1'b0;
            end
        end
        if (valid && write) begin
            if (space == 2'd0 && addr[7:5] < 3'd4 && addr[4:0] == 5'h0A) m_mk[addr[7:5]] = wdata;
            if (space == 2'd1 && addr == 8'd1) m_vec = wdata;
        end
        if (do_rd) m_rd = e_rd;
        chk("R5 irq model", {6'd0, irq}, {6'd0, e_irq});
        chk("R10 rdata model", rdata, m_rd);
        idle();
    endtask

    task automatic rd(logic [1:0] sp, logic [7:0] a);
        valid = 1'b1; write = 1'b0; space = sp; addr = a;
        tick();
    endtask

    task automatic wr(logic [1:0] sp, logic [7:0] a, logic [7:0] d);
        valid = 1'b1; write = 1'b1; space = sp; addr = a; wdata = d;
        tick();
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        for (int b = 0; b < 4; b++) begin m_st[b] = 8'h00; m_mk[b] = 8'h00; end
        m_vec = 8'h00; m_rd = 8'h00;
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 irq after reset", {6'd0, irq}, 8'h00);
        chk("R9 rdata after reset", rdata, 8'h00);
        rst = 1'b0;

        rd(2'd2, 8'd0);  chk("R9 vector zero", rdata, 8'h00);
        for (int b = 0; b < 4; b++) begin
            rd(2'd0, 8'(b*32 + 10)); chk("R9 status zero", rdata, 8'h00);
        end

        // R2 mapping: channel 5 transmit-ready -> block 2 bit 4
        eset[5*3+0] = 1'b1; tick();
        rd(2'd0, 8'h4A); chk("R2 odd channel lane", rdata, 8'h10);
        // channel 0 break -> block 0 bit 2
        eset[0*3+2] = 1'b1; tick();
        rd(2'd0, 8'h0A); chk("R2 even channel lane", rdata, 8'h04);
        // R3 set and clear together on channel 3 receive -> block 1 bit 5
        eset[3*3+1] = 1'b1; eclr[3*3+1] = 1'b1; tick();
        rd(2'd0, 8'h2A); chk("R3 set wins", rdata, 8'h20);
        eclr[3*3+1] = 1'b1; tick();
        rd(2'd0, 8'h2A); chk("R3 clear", rdata, 8'h00);

        // R1 decoys: offset 0x0A (addr 0x0B) and block index 4
        wr(2'd0, 8'h0B, 8'hFF);
        wr(2'd0, 8'h8A, 8'hFF);
        tick();
        chk("R1 decoy writes leave mask", {6'd0, irq}, 8'h00);
        rd(2'd0, 8'h8A); chk("R1 block 4 reads zero", rdata, 8'h00);
        rd(2'd0, 8'h0B); chk("R1 other offset reads zero", rdata, 8'h00);

        // R5 staging
        wr(2'd0, 8'h0A, 8'h04);
        chk("R5 irq not yet", {6'd0, irq}, 8'h00);
        tick();
        chk("R5 irq0 one cycle after mask", {6'd0, irq}, 8'h01);
        wr(2'd0, 8'h6A, 8'h20);
        eset[7*3+1] = 1'b1; tick();
        chk("R5 irq1 waits", {6'd0, irq}, 8'h01);
        tick();
        chk("R5 irq1 raised", {6'd0, irq}, 8'h03);
        rd(2'd0, 8'h6A); chk("R4 read gives status not mask", rdata, 8'h20);
        eclr[0*3+2] = 1'b1; tick();
        tick();
        chk("R5 irq0 dropped", {6'd0, irq}, 8'h02);

        // R6 / R7 vector
        wr(2'd1, 8'd3, 8'h77);
        rd(2'd2, 8'd0); chk("R6 other ID write ignored", rdata, 8'h00);
        wr(2'd1, 8'd1, 8'h5C);
        rd(2'd2, 8'd0); chk("R6 vector stored", rdata, 8'h5C);
        rd(2'd2, 8'd2); chk("R7 ack addr 2", rdata, 8'h5C);
        rd(2'd2, 8'd1); chk("R7 ack addr 1 zero", rdata, 8'h00);
        rd(2'd2, 8'd4); chk("R7 ack addr 4 zero", rdata, 8'h00);

        // R8 identification table
        rd(2'd1, 8'd0);   chk("R8 entry 0", rdata, 8'h53);
        rd(2'd1, 8'd7);   chk("R8 entry 3 odd addr", rdata, 8'h38);
        rd(2'd1, 8'd22);  chk("R8 last entry", rdata, 8'hA5);
        rd(2'd1, 8'd24);  chk("R8 past end", rdata, 8'h00);
        rd(2'd1, 8'd255); chk("R8 far past end", rdata, 8'h00);

        // R10 hold and unused space
        rd(2'd1, 8'd2);   chk("R10 read", rdata, 8'h49);
        tick();           chk("R10 hold", rdata, 8'h49);
        wr(2'd1, 8'd9, 8'hEE); chk("R10 write no update", rdata, 8'h49);
        rd(2'd3, 8'd0);   chk("R10 unused space zero", rdata, 8'h00);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom % 8);
            eset = EV_W'($urandom & $urandom & $urandom);
            eclr = EV_W'($urandom & $urandom & $urandom);
            case (r)
                0, 1, 2: begin
                    valid = 1'b1; write = 1'b0; space = 2'd0;
                    addr = ($urandom % 4 == 0) ? 8'($urandom) : 8'(($urandom % 4) * 32 + 10);
                end
                3: begin
                    valid = 1'b1; write = 1'b1; space = 2'd0;
                    addr = 8'(($urandom % 5) * 32 + 10); wdata = 8'($urandom);
                end
                4: begin valid = 1'b1; write = 1'b0; space = 2'd2; addr = 8'($urandom % 5); end
                5: begin valid = 1'b1; write = 1'b0; space = 2'd1; addr = 8'($urandom % 32); end
                6: begin
                    valid = 1'b1; write = 1'b1; space = 2'd1;
                    addr = 8'($urandom % 4); wdata = 8'($urandom);
                end
                default: ;
            endcase
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule